// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits next to a program counter and repeats a stretch of code a programmed number of times, so the loop body needs no branch instruction. A setup request loads three values: the first address of the body, the address just past the body, and a repeat count. A nonzero count marks the loop as running.

After each retired instruction the sequencer looks at the program counter that execution would move to next. If a loop is running and that address equals the stored end address, the counter steps down by one. While the counter is still above zero, the sequencer sends a redirect back to the start of the body in the same cycle. When the counter reaches zero, the loop stops and execution continues past the end.

A setup with a count of zero does not start a loop. It redirects straight to the given end address, so the body is skipped. A setup arriving while a loop runs replaces the running loop. Addresses are word addresses.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, loop_active is 0, loop_count is 0 and redirect_valid is 0.
- R2: A setup with a nonzero count stores the body start, the end address and the count. From the next cycle loop_active is 1 and loop_count shows the count.
- R3: When an instruction retires with loop_active=1, pc_next equal to the stored end address and a count above 1, redirect_valid is 1 in that cycle with redirect_pc equal to the stored body start. From the next cycle loop_count is one lower.
- R4: When such a match happens with a count of exactly 1, redirect_valid stays 0 and from the next cycle loop_active is 0 and loop_count is 0.
- R5: With no setup, a cycle with retire=0, a pc_next that differs from the end address, or loop_active=0 gives redirect_valid=0 and leaves loop_active and loop_count unchanged.
- R6: A setup with count 0 leaves loop_active at 0 and drives redirect_valid=1 with redirect_pc equal to setup_end in the same cycle.
- R7: A setup overwrites any running loop. When a setup and an end-address match fall in the same cycle, the setup alone decides the redirect and the next state.
- R8: Whenever an end-address match is acted on, the stored count is nonzero. Equivalently, loop_count is never 0 while loop_active is 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_valid | input | 1 | Load a new loop in this cycle |
| setup_top | input | AW | First word address of the body |
| setup_end | input | AW | Word address just past the body |
| setup_count | input | CW | Number of passes through the body |
| retire | input | 1 | An instruction completes in this cycle |
| pc_next | input | AW | Address execution would move to next |
| redirect_valid | output | 1 | Replace the next PC with redirect_pc |
| redirect_pc | output | AW | Replacement PC |
| loop_active | output | 1 | A loop is running |
| loop_count | output | CW | Passes remaining |

## Verification
A setup and an end-address match can land in the same cycle. The bench provokes this on purpose: it issues a new setup while a loop runs and drives pc_next to the old end address with retire high. It also lets random traffic hit this case often, by choosing pc_next from the model's end address about half the time while setups arrive at random. In every such cycle the bench's reference model applies the setup and discards the match. It then compares the redirect in that cycle, and loop_active and loop_count in the next cycle, against the model.

// File: rtl/zol_pkg.sv
package zol_pkg;

   // Action the decision logic requests from the state holder in a cycle.
   typedef enum logic [1:0] {
      ZA_HOLD = 2'd0,
      ZA_LOAD = 2'd1,
      ZA_WRAP = 2'd2,
      ZA_EXIT = 2'd3
   } zol_act_e;

endpackage

// File: rtl/zol_decide.sv
module zol_decide
   import zol_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          active_i,
   input  logic [AW-1:0] top_i,
   input  logic [AW-1:0] end_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          setup_i,
   input  logic [AW-1:0] setup_end_i,
   input  logic [CW-1:0] setup_count_i,
   input  logic          retire_i,
   input  logic [AW-1:0] pc_next_i,
   output zol_act_e      act_o,
   output logic          redirect_o,
   output logic [AW-1:0] redirect_pc_o
);

   localparam logic [CW-1:0] LastPass = CW'(1);

   logic hit;

   always_comb begin
      hit           = active_i & retire_i & (pc_next_i == end_i);
      act_o         = ZA_HOLD;
      redirect_o    = 1'b0;
      redirect_pc_o = top_i;
      if (setup_i) begin
         act_o = ZA_LOAD;
         if (setup_count_i == '0) begin
            redirect_o    = 1'b1;
            redirect_pc_o = setup_end_i;
         end
      end else if (hit) begin
         if (cnt_i == LastPass) begin
            act_o = ZA_EXIT;
         end else begin
            act_o      = ZA_WRAP;
            redirect_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/zol_state.sv
module zol_state
   import zol_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  zol_act_e      act_i,
   input  logic [AW-1:0] setup_top_i,
   input  logic [AW-1:0] setup_end_i,
   input  logic [CW-1:0] setup_count_i,
   output logic          active_o,
   output logic [AW-1:0] top_o,
   output logic [AW-1:0] end_o,
   output logic [CW-1:0] cnt_o
);

   localparam logic [CW-1:0] One = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         top_o    <= '0;
         end_o    <= '0;
         cnt_o    <= '0;
      end else begin
         unique case (act_i)
            ZA_LOAD: begin
               top_o    <= setup_top_i;
               end_o    <= setup_end_i;
               cnt_o    <= setup_count_i;
               active_o <= (setup_count_i != '0);
            end
            ZA_WRAP: cnt_o <= cnt_o - One;
            ZA_EXIT: begin
               cnt_o    <= cnt_o - One;
               active_o <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // R8
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ZA_WRAP || act_i == ZA_EXIT) |-> cnt_o != '0);
   // R3
   wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_i == ZA_WRAP |=> active_o && cnt_o == CW'($past(cnt_o) - One));
   // R4
   exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_i == ZA_EXIT |=> !active_o && cnt_o == '0);
   // R6
   zero_setup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ZA_LOAD && setup_count_i == '0) |=> !active_o);

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
   import zol_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup_valid,
   input  logic [AW-1:0] setup_top,
   input  logic [AW-1:0] setup_end,
   input  logic [CW-1:0] setup_count,
   input  logic          retire,
   input  logic [AW-1:0] pc_next,
   output logic          redirect_valid,
   output logic [AW-1:0] redirect_pc,
   output logic          loop_active,
   output logic [CW-1:0] loop_count
);

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("zol_ctrl: AW out of range");
   end
   if (CW < 1 || CW > 32) begin : g_bad_cw
      $error("zol_ctrl: CW out of range");
   end

   zol_act_e      act;
   logic [AW-1:0] top_q;
   logic [AW-1:0] end_q;

   zol_decide #(.AW(AW), .CW(CW)) u_decide (
      .active_i      (loop_active),
      .top_i         (top_q),
      .end_i         (end_q),
      .cnt_i         (loop_count),
      .setup_i       (setup_valid),
      .setup_end_i   (setup_end),
      .setup_count_i (setup_count),
      .retire_i      (retire),
      .pc_next_i     (pc_next),
      .act_o         (act),
      .redirect_o    (redirect_valid),
      .redirect_pc_o (redirect_pc)
   );

   zol_state #(.AW(AW), .CW(CW)) u_state (
      .clk           (clk),
      .rst_n         (rst_n),
      .act_i         (act),
      .setup_top_i   (setup_top),
      .setup_end_i   (setup_end),
      .setup_count_i (setup_count),
      .active_o      (loop_active),
      .top_o         (top_q),
      .end_o         (end_q),
      .cnt_o         (loop_count)
   );

   // R5
   idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_active && !setup_valid) |-> !redirect_valid);
   // R5
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!setup_valid && !retire) |=> $stable(loop_active) && $stable(loop_count));
   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_valid && setup_count != '0) |=> loop_active && loop_count == $past(setup_count));

endmodule

// File: tb/zol_ctrl_tb.sv
module zol_ctrl_tb;
   localparam int AW = 16;
   localparam int CW = 8;
   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          setup_valid = 1'b0;
   logic [AW-1:0] setup_top = '0;
   logic [AW-1:0] setup_end = '0;
   logic [CW-1:0] setup_count = '0;
   logic          retire = 1'b0;
   logic [AW-1:0] pc_next = '0;
   logic          redirect_valid;
   logic [AW-1:0] redirect_pc;
   logic          loop_active;
   logic [CW-1:0] loop_count;

   int checks = 0;
   int failures = 0;

   logic          m_act = 1'b0;
   logic [AW-1:0] m_top = '0;
   logic [AW-1:0] m_end = '0;
   logic [CW-1:0] m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zol_ctrl #(.AW(AW), .CW(CW)) u_dut (
      .clk, .rst_n, .setup_valid, .setup_top, .setup_end, .setup_count,
      .retire, .pc_next, .redirect_valid, .redirect_pc, .loop_active, .loop_count
   );

   task automatic chk(input string rq, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s got=%0h exp=%0h", rq, what, got, exp);
      end
   endtask

   // Drive one cycle, compare against the model, then advance the model.
   task automatic step(input string rq, input logic s, input logic [AW-1:0] t,
                       input logic [AW-1:0] e, input logic [CW-1:0] c,
                       input logic r, input logic [AW-1:0] p);
      logic          hit;
      logic          erv;
      logic [AW-1:0] epc;
      setup_valid = s; setup_top = t; setup_end = e; setup_count = c;
      retire = r; pc_next = p;
      #1;
      hit = m_act && r && (p == m_end);
      erv = 1'b0;
      epc = '0;
      if (s) begin
         if (c == 0) begin erv = 1'b1; epc = e; end
      end else if (hit && m_cnt != 1) begin
         erv = 1'b1; epc = m_top;
      end
      chk(rq, "loop_active", 32'(loop_active), 32'(m_act));
      chk(rq, "loop_count", 32'(loop_count), 32'(m_cnt));
      chk(rq, "redirect_valid", 32'(redirect_valid), 32'(erv));
      if (erv) chk(rq, "redirect_pc", 32'(redirect_pc), 32'(epc));
      // R8: a running loop never shows a zero count
      if (loop_active) chk("R8", "count_nonzero", 32'(loop_count != 0), 32'd1);
      if (s) begin
         m_top = t; m_end = e; m_cnt = c; m_act = (c != 0);
      end else if (hit) begin
         m_cnt = m_cnt - 1'b1;
         if (m_cnt == 0) m_act = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "loop_active", 32'(loop_active), 32'd0);
      chk("R1", "loop_count", 32'(loop_count), 32'd0);
      chk("R1", "redirect_valid", 32'(redirect_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: load three passes, body 0x10..0x13, end 0x14
      step("R2", 1, 16'h10, 16'h14, 3, 1, 16'h01);
      // R5: mismatched pc, then matching pc without retire
      step("R5", 0, 0, 0, 0, 1, 16'h12);
      step("R5", 0, 0, 0, 0, 0, 16'h14);
      // R3: two wraps
      step("R3", 0, 0, 0, 0, 1, 16'h14);
      step("R3", 0, 0, 0, 0, 1, 16'h14);
      // R4: final pass falls through
      step("R4", 0, 0, 0, 0, 1, 16'h14);
      // R5: inactive, end address seen again
      step("R5", 0, 0, 0, 0, 1, 16'h14);
      // R6: zero count skips the body
      step("R6", 1, 16'h20, 16'h40, 0, 1, 16'h21);
      step("R6", 0, 0, 0, 0, 1, 16'h40);
      // R7: setup overrides a running loop and a same-cycle match
      step("R7", 1, 16'h30, 16'h34, 2, 1, 16'h31);
      step("R7", 1, 16'h50, 16'h58, 5, 1, 16'h34);
      step("R7", 0, 0, 0, 0, 1, 16'h34);
      step("R7", 0, 0, 0, 0, 1, 16'h58);
      // R7: zero setup cancels a running loop in a match cycle
      step("R7", 1, 16'h60, 16'h70, 0, 1, 16'h58);
      step("R7", 0, 0, 0, 0, 1, 16'h58);

      // Random traffic, R2..R8
      for (int i = 0; i < 4000; i++) begin
         logic          s;
         logic [AW-1:0] p;
         s = ($urandom % 12) == 0;
         p = ($urandom % 2) ? m_end : AW'($urandom % 8);
         step("R7", s, AW'($urandom % 8), AW'($urandom % 8), CW'($urandom % 5),
              logic'($urandom % 2), p);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule